// File: doc/BRIEF.md
# Block-Exit Chain Predictor

This block predicts where control leaves each extended basic block. It does not keep taken/not-taken state for every branch. A direct-mapped table is indexed by the block's entry address. Each valid entry holds a tag, the predicted exit target and a two-bit confidence counter. The predicted target of one block is used as the lookup key for the next block. Starting from one address, the block therefore produces a stream of predicted block addresses, one per cycle, for an instruction prefetcher to use ahead of execution.

The execution side feeds back each resolved block exit. A correct resolution allows the chain to run one step further ahead. A mispredict discards every prediction still in flight and signals a flush. After a fixed recovery latency, chaining restarts from the corrected target. The table can be filled in bulk from a precomputed image, one entry per cycle, before or during operation.

Top module: `exit_chain_predictor`

## Requirements
- R1: After reset, `pred_valid_o` and `flush_o` are low and every table entry is invalid.
- R2: A start sampled on a clock edge makes the chain active at that key. For each active cycle whose lookup hits, the next edge registers one prediction. Its address is the stored target and its confidence is the stored counter. That target becomes the next key.
- R3: The lookup index is the low log2(ENTRIES) bits of the key and the tag is the remaining high bits. An invalid entry or a tag mismatch ends the chain with no prediction, and later resolves do not revive it.
- R4: At most MAX_AHEAD (4) predictions are outstanding beyond the resolved point. Each resolve without the mispredict flag releases one step, and a start or restart clears the count.
- R5: A seed write stores its target with confidence 2 (binary 10). No lookup advances in a cycle where a seed write is presented.
- R6: When a seed write and a resolve arrive in the same cycle, only the seed write updates the table. The resolve still releases a step or triggers a flush.
- R7: A resolve whose entry hits with the same target increments the confidence, saturating at 3. Any other resolve rewrites the entry with the actual target and confidence 1.
- R8: A mispredict sampled on edge M drops any prediction from that edge and raises `flush_o` for exactly the cycle after M. The first prediction from the corrected target is registered on edge M+5 (REC_LAT), and no prediction appears before it.
- R9: A start that is not a mispredict restarts the chain from the new key, replacing any chain or recovery in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_valid_i | input | 1 | Begin chaining at `start_addr_i` |
| start_addr_i | input | ADDR_W | First lookup key |
| seed_valid_i | input | 1 | Bulk table write this cycle |
| seed_addr_i | input | ADDR_W | Block entry address for the seed write |
| seed_target_i | input | ADDR_W | Exit target for the seed write |
| resolve_valid_i | input | 1 | A block exit has been resolved |
| resolve_mispredict_i | input | 1 | The resolved exit was mispredicted |
| resolve_addr_i | input | ADDR_W | Entry address of the resolved block |
| resolve_target_i | input | ADDR_W | Actual exit target |
| pred_valid_o | output | 1 | A chained prediction is present |
| pred_addr_o | output | ADDR_W | Predicted next block address |
| pred_conf_o | output | 2 | Confidence of the prediction |
| flush_o | output | 1 | Discard all unconsumed predictions |

## Verification
The bench makes a seed write and a resolve collide on the same entry in one cycle. It sends the two different targets. It then restarts the chain at that entry and expects the seeded target with confidence 2. It also expects the resolve's step release to have let the stalled chain advance exactly once. The bench holds a seed across several cycles while a resolve releases a step, and checks that no prediction appears until the seed drops. A mispredict is presented in the same cycle as an active lookup. The bench checks that the lookup's result is dropped and that predictions from the corrected target begin on the fifth edge.

// File: rtl/ecp_pkg.sv
`timescale 1ns/1ps
package ecp_pkg;
  typedef logic [1:0] conf_t;

  localparam conf_t CONF_NEW  = 2'd1;
  localparam conf_t CONF_SEED = 2'd2;
  localparam conf_t CONF_MAX  = 2'd3;

  function automatic conf_t conf_inc(input conf_t c);
    return (c == CONF_MAX) ? CONF_MAX : conf_t'(c + conf_t'(1));
  endfunction
endpackage

// File: rtl/ecp_table.sv
`timescale 1ns/1ps
module ecp_table
  import ecp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [ADDR_W-1:0] lk_target_o,
  output conf_t             lk_conf_o,
  input  logic              seed_valid_i,
  input  logic [ADDR_W-1:0] seed_addr_i,
  input  logic [ADDR_W-1:0] seed_target_i,
  input  logic              res_valid_i,
  input  logic [ADDR_W-1:0] res_addr_i,
  input  logic [ADDR_W-1:0] res_target_i
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              valid_q [ENTRIES];
  logic [TAG_W-1:0]  tag_q   [ENTRIES];
  logic [ADDR_W-1:0] tgt_q   [ENTRIES];
  conf_t             conf_q  [ENTRIES];

  logic [IDX_W-1:0]  lk_idx, s_idx, r_idx, wr_idx;
  logic [TAG_W-1:0]  lk_tag, s_tag, r_tag, wr_tag;
  logic [ADDR_W-1:0] wr_tgt;
  conf_t             wr_conf;
  logic              wr_en, r_hit;

  assign lk_idx = lk_addr_i[IDX_W-1:0];
  assign lk_tag = lk_addr_i[ADDR_W-1:IDX_W];
  assign s_idx  = seed_addr_i[IDX_W-1:0];
  assign s_tag  = seed_addr_i[ADDR_W-1:IDX_W];
  assign r_idx  = res_addr_i[IDX_W-1:0];
  assign r_tag  = res_addr_i[ADDR_W-1:IDX_W];

  assign lk_hit_o    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_target_o = tgt_q[lk_idx];
  assign lk_conf_o   = conf_q[lk_idx];
  assign r_hit       = valid_q[r_idx] && (tag_q[r_idx] == r_tag);

  // seed has priority over resolve
  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = s_idx;
    wr_tag  = s_tag;
    wr_tgt  = seed_target_i;
    wr_conf = CONF_SEED;
    if (seed_valid_i) begin
      wr_en = 1'b1;
    end else if (res_valid_i) begin
      wr_en  = 1'b1;
      wr_idx = r_idx;
      wr_tag = r_tag;
      wr_tgt = res_target_i;
      if (r_hit && (tgt_q[r_idx] == res_target_i)) wr_conf = conf_inc(conf_q[r_idx]);
      else                                        wr_conf = CONF_NEW;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   valid_q[g] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(g)))       valid_q[g] <= 1'b1;
    end
    always_ff @(posedge clk_i) begin
      if (wr_en && (wr_idx == IDX_W'(g))) begin
        tag_q[g]  <= wr_tag;
        tgt_q[g]  <= wr_tgt;
        conf_q[g] <= wr_conf;
      end
    end
  end

  // R5 R6
  seed_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_valid_i |=> (valid_q[$past(s_idx)] && tgt_q[$past(s_idx)] == $past(seed_target_i)
                      && conf_q[$past(s_idx)] == CONF_SEED));
  // R7
  conf_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_conf_o != 2'd0));
endmodule

// File: rtl/ecp_chain.sv
`timescale 1ns/1ps
module ecp_chain
  import ecp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MAX_AHEAD = 4,
  parameter int REC_LAT   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              mispred_i,
  input  logic [ADDR_W-1:0] redirect_i,
  input  logic              res_ok_i,
  input  logic              seed_busy_i,
  output logic [ADDR_W-1:0] lk_addr_o,
  input  logic              lk_hit_i,
  input  logic [ADDR_W-1:0] lk_target_i,
  input  conf_t             lk_conf_i,
  output logic              pred_valid_o,
  output logic [ADDR_W-1:0] pred_addr_o,
  output conf_t             pred_conf_o,
  output logic              flush_o
);
  localparam int AHW = $clog2(MAX_AHEAD + 1);
  localparam int RCW = $clog2(REC_LAT + 1);

  logic              active_q;
  logic [ADDR_W-1:0] key_q, rkey_q;
  logic [AHW-1:0]    ahead_q, ahead_nxt;
  logic [RCW-1:0]    rcnt_q;
  logic              look_en, credit, emit;

  assign lk_addr_o = key_q;
  assign look_en   = active_q && !seed_busy_i && (rcnt_q == '0) && (ahead_q < AHW'(MAX_AHEAD));
  assign emit      = look_en && lk_hit_i;
  assign credit    = res_ok_i && (ahead_q != '0);

  always_comb begin
    ahead_nxt = ahead_q;
    if (emit)   ahead_nxt = ahead_nxt + AHW'(1);
    if (credit) ahead_nxt = ahead_nxt - AHW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q     <= 1'b0;
      key_q        <= '0;
      rkey_q       <= '0;
      ahead_q      <= '0;
      rcnt_q       <= '0;
      pred_valid_o <= 1'b0;
      pred_addr_o  <= '0;
      pred_conf_o  <= '0;
      flush_o      <= 1'b0;
    end else begin
      pred_valid_o <= 1'b0;
      flush_o      <= 1'b0;
      if (mispred_i) begin
        flush_o  <= 1'b1;
        active_q <= 1'b0;
        ahead_q  <= '0;
        rkey_q   <= redirect_i;
        rcnt_q   <= RCW'(REC_LAT - 1);
      end else if (start_i) begin
        active_q <= 1'b1;
        key_q    <= start_addr_i;
        ahead_q  <= '0;
        rcnt_q   <= '0;
      end else if (rcnt_q != '0) begin
        rcnt_q <= rcnt_q - RCW'(1);
        if (rcnt_q == RCW'(1)) begin
          active_q <= 1'b1;
          key_q    <= rkey_q;
          ahead_q  <= '0;
        end
      end else begin
        ahead_q <= ahead_nxt;
        if (look_en) begin
          if (lk_hit_i) begin
            pred_valid_o <= 1'b1;
            pred_addr_o  <= lk_target_i;
            pred_conf_o  <= lk_conf_i;
            key_q        <= lk_target_i;
          end else begin
            active_q <= 1'b0;
          end
        end
      end
    end
  end

  // R4
  ahead_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ahead_q <= AHW'(MAX_AHEAD));
  // R4
  pred_counted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> (ahead_q != '0));
  // R5
  seed_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_busy_i && !start_i && !mispred_i) |=> $stable(key_q));
  // R8
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispred_i |=> (flush_o && !pred_valid_o));
  // R8
  recov_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rcnt_q != '0) |-> !pred_valid_o);
endmodule

// File: rtl/exit_chain_predictor.sv
`timescale 1ns/1ps
module exit_chain_predictor
  import ecp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ENTRIES   = 64,
  parameter int MAX_AHEAD = 4,
  parameter int REC_LAT   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_valid_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              seed_valid_i,
  input  logic [ADDR_W-1:0] seed_addr_i,
  input  logic [ADDR_W-1:0] seed_target_i,
  input  logic              resolve_valid_i,
  input  logic              resolve_mispredict_i,
  input  logic [ADDR_W-1:0] resolve_addr_i,
  input  logic [ADDR_W-1:0] resolve_target_i,
  output logic              pred_valid_o,
  output logic [ADDR_W-1:0] pred_addr_o,
  output logic [1:0]        pred_conf_o,
  output logic              flush_o
);
  logic              mispred, res_ok, lk_hit;
  logic [ADDR_W-1:0] lk_addr, lk_target;
  conf_t             lk_conf, p_conf;

  assign mispred     = resolve_valid_i && resolve_mispredict_i;
  assign res_ok      = resolve_valid_i && !resolve_mispredict_i;
  assign pred_conf_o = p_conf;

  ecp_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_table (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lk_addr_i     (lk_addr),
    .lk_hit_o      (lk_hit),
    .lk_target_o   (lk_target),
    .lk_conf_o     (lk_conf),
    .seed_valid_i  (seed_valid_i),
    .seed_addr_i   (seed_addr_i),
    .seed_target_i (seed_target_i),
    .res_valid_i   (resolve_valid_i),
    .res_addr_i    (resolve_addr_i),
    .res_target_i  (resolve_target_i)
  );

  ecp_chain #(.ADDR_W(ADDR_W), .MAX_AHEAD(MAX_AHEAD), .REC_LAT(REC_LAT)) u_chain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_valid_i),
    .start_addr_i (start_addr_i),
    .mispred_i    (mispred),
    .redirect_i   (resolve_target_i),
    .res_ok_i     (res_ok),
    .seed_busy_i  (seed_valid_i),
    .lk_addr_o    (lk_addr),
    .lk_hit_i     (lk_hit),
    .lk_target_i  (lk_target),
    .lk_conf_i    (lk_conf),
    .pred_valid_o (pred_valid_o),
    .pred_addr_o  (pred_addr_o),
    .pred_conf_o  (p_conf),
    .flush_o      (flush_o)
  );

  // R9
  start_clears_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_valid_i && !mispred) |=> !flush_o);
endmodule

// File: tb/exit_chain_predictor_test.sv
`timescale 1ns/1ps
module exit_chain_predictor_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_valid_i = 0, seed_valid_i = 0, resolve_valid_i = 0, resolve_mispredict_i = 0;
  logic [15:0] start_addr_i = '0, seed_addr_i = '0, seed_target_i = '0;
  logic [15:0] resolve_addr_i = '0, resolve_target_i = '0;
  logic        pred_valid_o, flush_o;
  logic [15:0] pred_addr_o;
  logic [1:0]  pred_conf_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  exit_chain_predictor uut (.*);

  function automatic logic [15:0] key(input int k);
    return 16'((k << 6) | k);
  endfunction

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic idle();
    start_valid_i = 0; seed_valid_i = 0; resolve_valid_i = 0; resolve_mispredict_i = 0;
  endtask

  task automatic chk_pred(input logic ev, input logic [15:0] ea, input logic [1:0] ec, input string req);
    checks++;
    if (pred_valid_o !== ev || (ev && (pred_addr_o !== ea || pred_conf_o !== ec))) begin
      errors++;
      $display("FAIL %s: got v=%0b a=%h c=%0d, exp v=%0b a=%h c=%0d",
               req, pred_valid_o, pred_addr_o, pred_conf_o, ev, ea, ec);
    end
  endtask

  task automatic chk_flush(input logic ef, input string req);
    checks++;
    if (flush_o !== ef) begin
      errors++;
      $display("FAIL %s: flush got %0b exp %0b", req, flush_o, ef);
    end
  endtask

  task automatic seed(input logic [15:0] a, input logic [15:0] t);
    seed_valid_i = 1; seed_addr_i = a; seed_target_i = t;
  endtask

  task automatic resolve(input logic mp, input logic [15:0] a, input logic [15:0] t);
    resolve_valid_i = 1; resolve_mispredict_i = mp; resolve_addr_i = a; resolve_target_i = t;
  endtask

  task automatic start(input logic [15:0] a);
    start_valid_i = 1; start_addr_i = a;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_ni = 1;
    tick();
    chk_pred(0, 0, 0, "R1");
    chk_flush(0, "R1");

    // empty table: chain misses at once (R3)
    start(key(0)); tick(); idle();
    tick(); chk_pred(0, 0, 0, "R3 empty");
    tick(); chk_pred(0, 0, 0, "R3 empty");

    // seed image while a start is pending: no lookups advance (R5)
    start(key(0));
    for (int k = 0; k <= 30; k++) begin
      seed(key(k), key(k + 1)); tick(); start_valid_i = 0;
      chk_pred(0, 0, 0, "R5 seeding");
    end
    idle();
    for (int k = 1; k <= 4; k++) begin
      tick(); chk_pred(1, key(k), 2'd2, "R2");
    end
    tick(); chk_pred(0, 0, 0, "R4 limit");
    tick(); chk_pred(0, 0, 0, "R4 limit");

    // one correct resolve releases one step (R4)
    resolve(0, key(0), key(1)); tick(); idle();
    chk_pred(0, 0, 0, "R4");
    tick(); chk_pred(1, key(5), 2'd2, "R4 release");
    tick(); chk_pred(0, 0, 0, "R4 relimit");

    // seed and resolve collide (R6)
    seed(key(1), key(50)); resolve(0, key(1), key(2)); tick(); idle();
    chk_pred(0, 0, 0, "R6");
    tick(); chk_pred(1, key(6), 2'd2, "R6 credit kept");
    tick(); chk_pred(0, 0, 0, "R6");

    // held seed stalls a granted step (R5)
    seed(key(20), key(21)); resolve(0, key(2), key(3)); tick(); resolve_valid_i = 0;
    chk_pred(0, 0, 0, "R5 hold");
    tick(); chk_pred(0, 0, 0, "R5 hold");
    tick(); chk_pred(0, 0, 0, "R5 hold");
    idle();
    tick(); chk_pred(1, key(7), 2'd2, "R5 resume");
    tick(); chk_pred(0, 0, 0, "R5");

    // restart picks seeded target; miss ends chain (R9 R6 R3)
    start(key(1)); tick(); idle();
    chk_pred(0, 0, 0, "R9");
    tick(); chk_pred(1, key(50), 2'd2, "R6 seed won");
    tick(); chk_pred(0, 0, 0, "R3 miss");
    resolve(0, key(3), key(4)); tick(); idle();
    chk_pred(0, 0, 0, "R3 no revive");
    tick(); chk_pred(0, 0, 0, "R3 no revive");

    // mispredict with lookup in flight (R8)
    start(key(10)); tick(); idle();
    tick(); chk_pred(1, key(11), 2'd2, "R9");
    tick(); chk_pred(1, key(12), 2'd2, "R9");
    resolve(1, key(10), key(20)); tick(); idle();
    chk_pred(0, 0, 0, "R8 drop");
    chk_flush(1, "R8");
    for (int k = 1; k <= 4; k++) begin
      tick(); chk_pred(0, 0, 0, "R8 recover");
      if (k == 1) chk_flush(0, "R8 one cycle");
    end
    for (int k = 21; k <= 24; k++) begin
      tick(); chk_pred(1, key(k), 2'd2, "R8 restart");
    end
    tick(); chk_pred(0, 0, 0, "R8 limit");

    // entry rewritten by mispredict (R7)
    start(key(10)); tick(); idle();
    tick(); chk_pred(1, key(20), 2'd1, "R7 rewrite");

    // confidence saturation and rewrite on new target (R7)
    resolve(0, key(5), key(6)); tick();
    tick(); idle();
    start(key(5)); tick(); idle();
    tick(); chk_pred(1, key(6), 2'd3, "R7 saturate");
    resolve(0, key(5), key(9)); tick(); idle();
    start(key(5)); tick(); idle();
    tick(); chk_pred(1, key(9), 2'd1, "R7 new target");

    // reseed and sweep every start point (R2 R3 R4)
    for (int k = 0; k <= 30; k++) begin
      seed(key(k), key(k + 1)); tick();
    end
    idle();
    for (int s = 0; s <= 30; s++) begin
      int n;
      n = (31 - s < 4) ? 31 - s : 4;
      start(key(s)); tick(); idle();
      for (int k = 0; k < 5; k++) begin
        tick();
        chk_pred(k < n, key(s + 1 + k), 2'd2, "R2 R3 R4 sweep");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule